// File: doc/BRIEF.md
# SMT Fetch Thread Scheduler

This block decides, once per clock, which of the hardware threads of a multithreaded core may fetch its next instruction group into the shared issue queues. A thread can be chosen only when software has switched it on and the front end is not holding it stalled. The grant covers one fetch group of up to four instructions, all from the chosen thread. The grant leaves the block registered, as a one-hot vector and as an index, together with a fetch-valid strobe.

Three policies are available. The default is occupancy mode: among the threads that may fetch, the one with the fewest instructions waiting in the issue queues wins. Each thread's count comes in from the queue logic and covers five 16-entry queues, so it runs from 0 to 80. Rotation mode hands fetch cycles to the threads in turn. Priority mode grants the eligible thread with the largest priority value. When threads tie under any policy, a rotating pointer settles it: the search starts at the thread after the one granted last. The policy select and the enable mask pass through a configuration register. The stall flags, occupancy counts and priorities are used as they arrive.

A two-state machine tracks whether a grant is being issued. In IDLE no thread is granted. In FETCH a grant is on the outputs. Any cycle with at least one eligible thread leads to FETCH, and any cycle without one leads to IDLE. Both transitions take effect at the following clock edge.

Top module: `smt_fetch_sched`

## Requirements
- R1: While and right after synchronous reset (rst_n low), fetch_valid is 0, grant_oh is 0, the enable mask register holds 0, the policy is occupancy, and the rotation pointer is thread 0.
- R2: With policy code 0 (occupancy), the grant goes to the eligible thread with the smallest occupancy count.
- R3: A tie under any policy goes to the first tied thread found by searching upward, with wrap, from the thread after the one granted last.
- R4: With policy code 1 (rotation), eligible threads are granted in turn, in ascending index order with wrap, whatever their occupancy or priority.
- R5: With policy code 2 (priority), the grant goes to the eligible thread with the largest priority value. Code 3 behaves like code 0.
- R6: A thread whose enable bit (cfg_thr_en bit i is thread i) is 0 in the configuration register is never granted.
- R7: A thread whose stall flag (thr_stall bit i) was high in the cycle the grant was computed is never granted.
- R8: When no thread is eligible, fetch_valid is 0 in the next cycle (state IDLE). When at least one thread is eligible, fetch_valid is 1 in the next cycle (state FETCH).
- R9: A new policy or enable mask is captured at one clock edge and governs the grant registered at the following edge. Stall, occupancy and priority inputs govern the grant registered at the next edge.
- R10: When fetch_valid is 1, grant_oh has exactly one bit set, bit grant_id. When fetch_valid is 0, grant_oh is 0.
- R11: Occupancy counts are compared over their full range of 0 to 80, so a count of 79 beats a count of 80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_policy | input | 2 | Policy: 0 occupancy, 1 rotation, 2 priority, 3 occupancy |
| cfg_thr_en | input | NUM_THR | Per-thread enable mask (bit i is thread i) |
| thr_stall | input | NUM_THR | Per-thread stall flags |
| thr_occ | input | NUM_THR*OCC_W | Per-thread queue occupancy, thread i in bits [i*OCC_W +: OCC_W] |
| thr_prio | input | NUM_THR*PRIO_W | Per-thread priority, thread i in bits [i*PRIO_W +: PRIO_W] |
| grant_oh | output | NUM_THR | One-hot grant |
| grant_id | output | THR_W | Index of the granted thread |
| fetch_valid | output | 1 | A grant is issued this cycle |

## Verification
The hardest case to reach is a tie in which the rotating pointer decides. The pointer is never visible at the ports, and it moves with every grant. The stimulus holds equal occupancy counts, or equal top priorities, across several cycles so that the pointer walks over the tied threads. In between, it masks or stalls the thread the pointer would pick next. The bench's reference model tracks the pointer from the requirements. It also keeps the one-cycle lag of the configuration register separate from the live stall inputs, so each cycle's expected grant accounts for a mode or mask written one cycle earlier.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic [1:0] {
        POL_OCC  = 2'd0,
        POL_ROT  = 2'd1,
        POL_PRIO = 2'd2,
        POL_RSVD = 2'd3
    } policy_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } sched_state_e;
endpackage

// File: rtl/sched_cfg_reg.sv
module sched_cfg_reg
    import sched_pkg::*;
#(
    parameter int NUM_THR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         policy_in,
    input  logic [NUM_THR-1:0] en_in,
    output policy_e            policy_q,
    output logic [NUM_THR-1:0] en_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            policy_q <= POL_OCC;
            en_q     <= '0;
        end else begin
            policy_q <= policy_e'(policy_in);
            en_q     <= en_in;
        end
    end
endmodule

// File: rtl/sched_key_gen.sv
module sched_key_gen
    import sched_pkg::*;
#(
    parameter int NUM_THR = 4,
    parameter int OCC_W   = 7,
    parameter int PRIO_W  = 2,
    parameter int KEY_W   = 7
) (
    input  policy_e                     policy,
    input  logic [NUM_THR*OCC_W-1:0]    occ,
    input  logic [NUM_THR*PRIO_W-1:0]   prio,
    output logic [NUM_THR*KEY_W-1:0]    keys
);
    // Smaller key wins: occupancy as is, inverted priority, or all equal.
    for (genvar t = 0; t < NUM_THR; t++) begin : g_key
        logic [OCC_W-1:0]  occ_t;
        logic [PRIO_W-1:0] prio_t;
        assign occ_t  = occ[t*OCC_W +: OCC_W];
        assign prio_t = prio[t*PRIO_W +: PRIO_W];
        always_comb begin
            unique case (policy)
                POL_ROT:  keys[t*KEY_W +: KEY_W] = '0;
                POL_PRIO: keys[t*KEY_W +: KEY_W] = KEY_W'(~prio_t);
                default:  keys[t*KEY_W +: KEY_W] = KEY_W'(occ_t);
            endcase
        end
    end
endmodule

// File: rtl/sched_pick.sv
module sched_pick #(
    parameter int NUM_THR = 4,
    parameter int KEY_W   = 7,
    parameter int THR_W   = 2
) (
    input  logic [NUM_THR-1:0]       elig,
    input  logic [NUM_THR*KEY_W-1:0] keys,
    input  logic [THR_W-1:0]         start,
    output logic                     any,
    output logic [THR_W-1:0]         idx
);
    // Scan from the rotating start; strict compare keeps the earliest tie.
    logic [KEY_W-1:0] best;
    int               pos;
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '1;
        pos  = 0;
        for (int k = 0; k < NUM_THR; k++) begin
            pos = (int'(start) + k) % NUM_THR;
            if (elig[pos] && (!any || keys[pos*KEY_W +: KEY_W] < best)) begin
                any  = 1'b1;
                best = keys[pos*KEY_W +: KEY_W];
                idx  = THR_W'(pos);
            end
        end
    end
endmodule

// File: rtl/smt_fetch_sched.sv
module smt_fetch_sched
    import sched_pkg::*;
#(
    parameter int NUM_THR  = 4,
    parameter int N_QUEUES = 5,
    parameter int Q_DEPTH  = 16,
    parameter int OCC_W    = $clog2(N_QUEUES * Q_DEPTH + 1),
    parameter int PRIO_W   = 2,
    parameter int THR_W    = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 cfg_policy,
    input  logic [NUM_THR-1:0]         cfg_thr_en,
    input  logic [NUM_THR-1:0]         thr_stall,
    input  logic [NUM_THR*OCC_W-1:0]   thr_occ,
    input  logic [NUM_THR*PRIO_W-1:0]  thr_prio,
    output logic [NUM_THR-1:0]         grant_oh,
    output logic [THR_W-1:0]           grant_id,
    output logic                       fetch_valid
);
    localparam int KEY_W = (OCC_W > PRIO_W) ? OCC_W : PRIO_W;

    policy_e            policy_q;
    logic [NUM_THR-1:0] cfg_en_q;
    logic [NUM_THR*KEY_W-1:0] keys;
    logic               pick_any;
    logic [THR_W-1:0]   pick_idx;
    logic [THR_W-1:0]   ptr_q;
    logic [THR_W-1:0]   grant_id_q;
    sched_state_e       state_q, state_d;

    sched_cfg_reg #(.NUM_THR(NUM_THR)) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .policy_in(cfg_policy), .en_in(cfg_thr_en),
        .policy_q(policy_q), .en_q(cfg_en_q)
    );

    sched_key_gen #(
        .NUM_THR(NUM_THR), .OCC_W(OCC_W), .PRIO_W(PRIO_W), .KEY_W(KEY_W)
    ) keys_i (
        .policy(policy_q), .occ(thr_occ), .prio(thr_prio), .keys(keys)
    );

    sched_pick #(.NUM_THR(NUM_THR), .KEY_W(KEY_W), .THR_W(THR_W)) pick_i (
        .elig(cfg_en_q & ~thr_stall), .keys(keys), .start(ptr_q),
        .any(pick_any), .idx(pick_idx)
    );

    // Next-state decision
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = pick_any ? ST_FETCH : ST_IDLE;
            ST_FETCH: state_d = pick_any ? ST_FETCH : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with grant index and rotation pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            grant_id_q <= '0;
            ptr_q      <= '0;
        end else begin
            state_q <= state_d;
            if (pick_any) begin
                grant_id_q <= pick_idx;
                ptr_q      <= (int'(pick_idx) == NUM_THR - 1) ? '0 : pick_idx + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        grant_oh    = '0;
        fetch_valid = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                fetch_valid          = 1'b1;
                grant_oh[grant_id_q] = 1'b1;
            end
            default: ;
        endcase
    end
    assign grant_id = grant_id_q;
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
    parameter int NUM_THR = 4,
    parameter int THR_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_THR-1:0] thr_stall,
    input logic [NUM_THR-1:0] cfg_en_q,
    input logic [NUM_THR-1:0] grant_oh,
    input logic [THR_W-1:0]   grant_id,
    input logic               fetch_valid
);
    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> ($countones(grant_oh) == 1 && grant_oh[grant_id]));
    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> (grant_oh == '0));
    assert_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (($past(cfg_en_q) & grant_oh) != '0));
    assert_not_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (($past(thr_stall) & grant_oh) == '0));
    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_en_q & ~thr_stall) == '0) |=> !fetch_valid);
    assert_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_en_q & ~thr_stall) != '0) |=> fetch_valid);
endmodule

bind smt_fetch_sched sched_chk #(.NUM_THR(NUM_THR), .THR_W(THR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .thr_stall(thr_stall), .cfg_en_q(cfg_en_q),
    .grant_oh(grant_oh), .grant_id(grant_id), .fetch_valid(fetch_valid)
);

// File: tb/smt_fetch_sched_tb_top.sv
module smt_fetch_sched_tb_top;
    localparam int NT = 4;
    localparam int OW = 7;
    localparam int PW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      cfg_policy = '0;
    logic [NT-1:0]   cfg_thr_en = '0;
    logic [NT-1:0]   thr_stall = '0;
    logic [NT*OW-1:0] thr_occ = '0;
    logic [NT*PW-1:0] thr_prio = '0;
    logic [NT-1:0]   grant_oh;
    logic [1:0]      grant_id;
    logic            fetch_valid;

    always #4 clk = ~clk;

    smt_fetch_sched dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_policy(cfg_policy), .cfg_thr_en(cfg_thr_en),
        .thr_stall(thr_stall), .thr_occ(thr_occ), .thr_prio(thr_prio),
        .grant_oh(grant_oh), .grant_id(grant_id), .fetch_valid(fetch_valid)
    );

    typedef struct {
        bit    vld;
        int    id;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;

    // Reference model state
    int        m_pol = 0;
    bit [3:0]  m_en  = '0;
    int        m_ptr = 0;

    task automatic drive(string tag, int pol, bit [3:0] en, bit [3:0] st,
                         int o0, int o1, int o2, int o3,
                         int p0, int p1, int p2, int p3);
        int occ[4];
        int pr[4];
        int key[4];
        exp_t e;
        int best;
        occ = '{o0, o1, o2, o3};
        pr  = '{p0, p1, p2, p3};
        @(negedge clk);
        cfg_policy = 2'(pol);
        cfg_thr_en = en;
        thr_stall  = st;
        thr_occ    = {7'(o3), 7'(o2), 7'(o1), 7'(o0)};
        thr_prio   = {2'(p3), 2'(p2), 2'(p1), 2'(p0)};
        for (int t = 0; t < 4; t++) begin
            if (m_pol == 1)      key[t] = 0;
            else if (m_pol == 2) key[t] = 3 - pr[t];
            else                 key[t] = occ[t];
        end
        e.vld = 0; e.id = 0; e.tag = tag; best = 0;
        for (int k = 0; k < 4; k++) begin
            int t;
            t = (m_ptr + k) % 4;
            if (m_en[t] && !st[t] && (!e.vld || key[t] < best)) begin
                e.vld = 1; e.id = t; best = key[t];
            end
        end
        if (e.vld) m_ptr = (e.id + 1) % 4;
        m_pol = pol;
        m_en  = en;
        exp_q.push_back(e);
    endtask

    // Monitor: compare outputs registered at each edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            bit ok;
            e = exp_q.pop_front();
            n_run++;
            if (e.vld) ok = fetch_valid && grant_id == 2'(e.id) && grant_oh == (4'b1 << e.id);
            else       ok = !fetch_valid && grant_oh == 4'b0;
            if (!ok) begin
                n_fail++;
                $display("FAIL %s: valid=%0d id=%0d oh=%b, expected valid=%0d id=%0d",
                         e.tag, fetch_valid, grant_id, grant_oh, e.vld, e.id);
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #2;
        // R1: reset state at the ports
        n_run++;
        if (fetch_valid !== 1'b0 || grant_oh !== 4'b0) begin
            n_fail++;
            $display("FAIL R1: valid=%0d oh=%b, expected valid=0 oh=0000", fetch_valid, grant_oh);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R9: enables written now only count one edge later
        drive("R9", 0, 4'b1111, 4'b0000, 0, 0, 0, 0, 0, 0, 0, 0);
        // R3: equal occupancy rotates from the pointer
        drive("R3", 0, 4'b1111, 4'b0000, 5, 5, 5, 5, 0, 0, 0, 0);
        drive("R3", 0, 4'b1111, 4'b0000, 5, 5, 5, 5, 0, 0, 0, 0);
        drive("R3", 0, 4'b1111, 4'b0000, 5, 5, 5, 5, 0, 0, 0, 0);
        drive("R3", 0, 4'b1111, 4'b0000, 5, 5, 5, 5, 0, 0, 0, 0);
        // R2: fewest queued wins
        drive("R2", 0, 4'b1111, 4'b0000, 10, 3, 40, 80, 0, 0, 0, 0);
        drive("R2", 0, 4'b1111, 4'b0000, 10, 3, 40, 80, 0, 0, 0, 0);
        drive("R2", 0, 4'b1111, 4'b0000, 20, 30, 2, 80, 3, 3, 3, 3);
        // R11: range edges
        drive("R11", 0, 4'b1111, 4'b0000, 80, 79, 80, 80, 0, 0, 0, 0);
        drive("R11", 0, 4'b1111, 4'b0000, 80, 80, 80, 0, 0, 0, 0, 0);
        drive("R11", 0, 4'b1111, 4'b0000, 64, 63, 80, 80, 0, 0, 0, 0);
        // R3: partial tie between threads 0 and 2
        drive("R3", 0, 4'b1111, 4'b0000, 7, 9, 7, 9, 0, 0, 0, 0);
        drive("R3", 0, 4'b1111, 4'b0000, 7, 9, 7, 9, 0, 0, 0, 0);
        drive("R3", 0, 4'b1111, 4'b0000, 7, 9, 7, 9, 0, 0, 0, 0);
        // R6: masked thread with the lowest count is skipped
        drive("R6", 0, 4'b0101, 4'b0000, 9, 0, 9, 0, 0, 0, 0, 0);
        drive("R6", 0, 4'b0101, 4'b0000, 9, 0, 9, 0, 0, 0, 0, 0);
        drive("R6", 0, 4'b0101, 4'b0000, 9, 0, 9, 0, 0, 0, 0, 0);
        drive("R6", 0, 4'b0101, 4'b0000, 9, 0, 9, 0, 0, 0, 0, 0);
        // R7: stalled thread with the lowest count is skipped
        drive("R7", 0, 4'b1111, 4'b0010, 9, 0, 8, 9, 0, 0, 0, 0);
        drive("R7", 0, 4'b1111, 4'b0110, 9, 0, 8, 9, 0, 0, 0, 0);
        // R8: nothing eligible
        drive("R8", 0, 4'b1111, 4'b1111, 1, 1, 1, 1, 0, 0, 0, 0);
        drive("R8", 0, 4'b0000, 4'b0000, 1, 1, 1, 1, 0, 0, 0, 0);
        drive("R8", 0, 4'b0000, 4'b0000, 1, 1, 1, 1, 0, 0, 0, 0);
        drive("R8", 0, 4'b1000, 4'b0000, 1, 1, 1, 1, 0, 0, 0, 0);
        drive("R8", 0, 4'b1000, 4'b0000, 1, 1, 1, 1, 0, 0, 0, 0);
        // R4: rotation mode ignores occupancy (mode change lands one edge later, R9)
        drive("R9", 1, 4'b1111, 4'b0000, 0, 80, 80, 80, 3, 0, 0, 0);
        for (int i = 0; i < 6; i++)
            drive("R4", 1, 4'b1111, 4'b0000, 0, 80, 80, 80, 3, 0, 0, 0);
        drive("R4", 1, 4'b1011, 4'b0000, 0, 80, 80, 80, 3, 0, 0, 0);
        for (int i = 0; i < 4; i++)
            drive("R4", 1, 4'b1011, 4'b0000, 0, 80, 80, 80, 3, 0, 0, 0);
        // R5: priority mode, ties between threads 1 and 3
        drive("R9", 2, 4'b1111, 4'b0000, 0, 80, 0, 80, 0, 3, 1, 3);
        for (int i = 0; i < 4; i++)
            drive("R5", 2, 4'b1111, 4'b0000, 0, 80, 0, 80, 0, 3, 1, 3);
        drive("R5", 2, 4'b1111, 4'b1010, 0, 80, 0, 80, 0, 3, 1, 3);
        drive("R5", 2, 4'b1111, 4'b0000, 0, 80, 0, 80, 2, 1, 0, 1);
        // R5: reserved code acts as occupancy
        drive("R5", 3, 4'b1111, 4'b0000, 30, 20, 10, 40, 3, 0, 0, 0);
        drive("R5", 3, 4'b1111, 4'b0000, 30, 20, 10, 40, 3, 0, 0, 0);
        drive("R5", 3, 4'b1111, 4'b0000, 30, 20, 10, 40, 3, 0, 0, 0);
        // Single active thread
        drive("R6", 0, 4'b0100, 4'b0000, 0, 0, 80, 0, 0, 0, 0, 0);
        drive("R6", 0, 4'b0100, 4'b0000, 0, 0, 80, 0, 0, 0, 0, 0);
        drive("R6", 0, 4'b0100, 4'b0000, 0, 0, 80, 0, 0, 0, 0, 0);

        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule